// File: doc/BRIEF.md
# Section Translation Table Walker

This block maps a 32-bit virtual address to a physical address using single-level descriptors that each cover one 1 MB section of the address space. The descriptors are stored in memory. A requester presents a virtual address on a valid/ready request channel. If translation is on, the walker works out where the descriptor sits in a 16 KB-aligned table and fetches that one word over a read port. This port carries physical addresses only, so the fetch is never translated. The walker then decodes the word and returns either a physical address with its cache, write-buffer and domain attributes, or a translation fault.

If translation is off when the request is accepted, the address is returned unchanged and marked cacheable, and no memory read takes place. Only one walk is in flight at a time. A result stays on the response channel until the requester takes it.

The controller is a four-state machine:
- `ST_IDLE` accepts a request. It moves to `ST_RESP` when translation is off and to `ST_FETCH` when it is on.
- `ST_FETCH` holds the descriptor read request until it is granted, then moves to `ST_WAIT`.
- `ST_WAIT` waits for read data, decodes it and moves to `ST_RESP`.
- `ST_RESP` presents the result until it is accepted, then returns to `ST_IDLE`.

Top module: `sect_xlate`

## Requirements
- R1: After reset, `req_ready` is 1 and both `rsp_valid` and `mem_req` are 0.
- R2: A request accepted while `xl_en` is 0 is answered in the next cycle without any memory read. The response has `rsp_pa` equal to the virtual address, `rsp_cache`=1, `rsp_buf`=0, `rsp_dom`=0 and `rsp_fault`=0.
- R3: With `xl_en`=1, the descriptor address is `{tbl_base[31:14], va[31:20], 2'b00}`, so the low 14 bits of `tbl_base` are ignored. `tbl_base`, `xl_en` and the address are all sampled in the cycle the request is accepted.
- R4: `mem_req` rises in the cycle after acceptance. It stays high with a stable `mem_addr` until `mem_gnt` is seen, and the descriptor is taken on the first `mem_rvalid` after the grant.
- R5: A descriptor with bits [1:0]=2'b10 and bit 18=0 is a valid section. For such a descriptor, `rsp_pa` = `{desc[31:20], va[19:0]}` and `rsp_fault`=0.
- R6: For a valid section, `rsp_cache` equals descriptor bit 3 and `rsp_buf` equals descriptor bit 2.
- R7: For a valid section, `rsp_dom` equals descriptor bits [8:5].
- R8: A descriptor whose bits [1:0] are 2'b00, 2'b01 or 2'b11, or which has bit 18 set, gives `rsp_fault`=1 with `rsp_pa`=0, `rsp_cache`=0, `rsp_buf`=0 and `rsp_dom`=0.
- R9: The response and its fields stay stable while `rsp_valid` is 1 and `rsp_ready` is 0. `req_ready` is 0 from acceptance until the response has been taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xl_en | input | 1 | Translation enable, sampled at request acceptance |
| tbl_base | input | 32 | Table base; bits [13:0] ignored |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Walker can accept a request |
| req_va | input | 32 | Virtual address |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Requester takes the result |
| rsp_pa | output | 32 | Physical address (0 on fault) |
| rsp_cache | output | 1 | Cacheable attribute |
| rsp_buf | output | 1 | Bufferable attribute |
| rsp_dom | output | 4 | Domain number |
| rsp_fault | output | 1 | Section translation fault |
| mem_req | output | 1 | Descriptor read request |
| mem_gnt | input | 1 | Read request granted |
| mem_addr | output | 32 | Physical descriptor address |
| mem_rvalid | input | 1 | Read data present |
| mem_rdata | input | 32 | Descriptor word |

## Verification
The first pattern sends the same virtual address with translation off and then on. This shows that pass-through returns the input address and that a walk returns the mapped address. Identity and remapped descriptors with different C, B and domain values test each field's bit position separately. All three non-section type codes, plus a section with bit 18 set, test the fault path. Other runs change the base and its low bits after acceptance, stall the grant and stall the response. These separate correct sampling at acceptance from sampling of live inputs, and show that the read request and the response are each held while stalled.

// File: rtl/sect_xlate_pkg.sv
package sect_xlate_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WAIT,
        ST_RESP
    } walk_state_t;

    localparam int DOM_W       = 4;
    localparam int BIT_BUF     = 2;
    localparam int BIT_CACHE   = 3;
    localparam int DOM_LSB     = 5;
    localparam int BIT_SUPER   = 18;
    localparam logic [1:0] SECTION_TAG = 2'b10;

    typedef struct packed {
        logic             cache;
        logic             buff;
        logic [DOM_W-1:0] dom;
        logic             fault;
    } xl_attr_t;

endpackage

// File: rtl/sect_desc_decode.sv
module sect_desc_decode
    import sect_xlate_pkg::*;
#(
    parameter int VA_W   = 32,
    parameter int SECT_W = 20
) (
    input  logic [VA_W-1:0]   desc,
    input  logic [SECT_W-1:0] va_off,
    output logic [VA_W-1:0]   pa,
    output xl_attr_t          attr
);

    logic is_section;
    logic unused_desc_bits;

    assign unused_desc_bits = ^{desc[SECT_W-1:BIT_SUPER+1],
                                desc[BIT_SUPER-1:DOM_LSB+DOM_W], desc[4]};

    assign is_section = (desc[1:0] == SECTION_TAG) && !desc[BIT_SUPER];

    always_comb begin
        if (is_section) begin
            pa         = {desc[VA_W-1:SECT_W], va_off};
            attr.cache = desc[BIT_CACHE];
            attr.buff  = desc[BIT_BUF];
            attr.dom   = desc[DOM_LSB +: DOM_W];
            attr.fault = 1'b0;
        end else begin
            pa         = '0;
            attr.cache = 1'b0;
            attr.buff  = 1'b0;
            attr.dom   = '0;
            attr.fault = 1'b1;
        end
    end

endmodule

// File: rtl/sect_walk_fsm.sv
module sect_walk_fsm
    import sect_xlate_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic xl_en,
    input  logic mem_gnt,
    input  logic mem_rvalid,
    input  logic rsp_ready,
    output logic req_ready,
    output logic mem_req,
    output logic rsp_valid,
    output logic accept,
    output logic load_desc
);

    walk_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx  = state;
        req_ready = 1'b0;
        mem_req   = 1'b0;
        rsp_valid = 1'b0;
        accept    = 1'b0;
        load_desc = 1'b0;
        unique case (state)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    accept   = 1'b1;
                    state_nx = xl_en ? ST_FETCH : ST_RESP;
                end
            end
            ST_FETCH: begin
                mem_req = 1'b1;
                if (mem_gnt) state_nx = ST_WAIT;
            end
            ST_WAIT: begin
                if (mem_rvalid) begin
                    load_desc = 1'b1;
                    state_nx  = ST_RESP;
                end
            end
            ST_RESP: begin
                rsp_valid = 1'b1;
                if (rsp_ready) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/sect_xlate.sv
module sect_xlate
    import sect_xlate_pkg::*;
#(
    parameter int VA_W   = 32,
    parameter int SECT_W = 20
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            xl_en,
    input  logic [VA_W-1:0] tbl_base,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [VA_W-1:0] req_va,
    output logic            rsp_valid,
    input  logic            rsp_ready,
    output logic [VA_W-1:0] rsp_pa,
    output logic            rsp_cache,
    output logic            rsp_buf,
    output logic [3:0]      rsp_dom,
    output logic            rsp_fault,
    output logic            mem_req,
    input  logic            mem_gnt,
    output logic [VA_W-1:0] mem_addr,
    input  logic            mem_rvalid,
    input  logic [VA_W-1:0] mem_rdata
);

    localparam int IDX_W   = VA_W - SECT_W;
    localparam int ALIGN_W = IDX_W + 2;

    logic              accept, load_desc;
    logic [SECT_W-1:0] va_off_q;
    logic [VA_W-1:0]   daddr_q, pa_q, dec_pa;
    xl_attr_t          attr_q, dec_attr;
    logic              unused_base_bits;

    assign unused_base_bits = ^tbl_base[ALIGN_W-1:0];

    sect_walk_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .xl_en      (xl_en),
        .mem_gnt    (mem_gnt),
        .mem_rvalid (mem_rvalid),
        .rsp_ready  (rsp_ready),
        .req_ready  (req_ready),
        .mem_req    (mem_req),
        .rsp_valid  (rsp_valid),
        .accept     (accept),
        .load_desc  (load_desc)
    );

    sect_desc_decode #(.VA_W(VA_W), .SECT_W(SECT_W)) u_dec (
        .desc   (mem_rdata),
        .va_off (va_off_q),
        .pa     (dec_pa),
        .attr   (dec_attr)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            va_off_q <= '0;
            daddr_q  <= '0;
            pa_q     <= '0;
            attr_q   <= '0;
        end else if (accept) begin
            va_off_q <= req_va[SECT_W-1:0];
            daddr_q  <= {tbl_base[VA_W-1:ALIGN_W], req_va[VA_W-1:SECT_W], 2'b00};
            if (!xl_en) begin
                pa_q   <= req_va;
                attr_q <= '{cache: 1'b1, buff: 1'b0, dom: '0, fault: 1'b0};
            end
        end else if (load_desc) begin
            pa_q   <= dec_pa;
            attr_q <= dec_attr;
        end
    end

    assign mem_addr  = daddr_q;
    assign rsp_pa    = pa_q;
    assign rsp_cache = attr_q.cache;
    assign rsp_buf   = attr_q.buff;
    assign rsp_dom   = attr_q.dom;
    assign rsp_fault = attr_q.fault;

endmodule

// File: rtl/sect_xlate_chk.sv
module sect_xlate_chk #(
    parameter int VA_W   = 32,
    parameter int SECT_W = 20
) (
    input logic            clk,
    input logic            rst_n,
    input logic            xl_en,
    input logic            req_valid,
    input logic            req_ready,
    input logic [VA_W-1:0] req_va,
    input logic            rsp_valid,
    input logic            rsp_ready,
    input logic [VA_W-1:0] rsp_pa,
    input logic            rsp_cache,
    input logic            rsp_buf,
    input logic [3:0]      rsp_dom,
    input logic            rsp_fault,
    input logic            mem_req,
    input logic            mem_gnt,
    input logic [VA_W-1:0] mem_addr
);

    logic [VA_W-1:0] va_seen;
    logic            en_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            va_seen <= '0;
            en_seen <= 1'b0;
        end else if (req_valid && req_ready) begin
            va_seen <= req_va;
            en_seen <= xl_en;
        end
    end

    p_reset_idle_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> req_ready && !rsp_valid && !mem_req);

    p_bypass_result_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !en_seen |-> rsp_pa == va_seen && rsp_cache && !rsp_buf
                                  && rsp_dom == 4'd0 && !rsp_fault);

    p_bypass_no_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> en_seen);

    p_hold_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_gnt |=> mem_req && $stable(mem_addr));

    p_offset_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && en_seen && !rsp_fault |-> rsp_pa[SECT_W-1:0] == va_seen[SECT_W-1:0]);

    p_fault_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault |-> rsp_pa == '0 && !rsp_cache && !rsp_buf && rsp_dom == 4'd0);

    p_hold_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_pa) && $stable(rsp_fault)
                                    && $stable(rsp_cache) && $stable(rsp_buf) && $stable(rsp_dom));

    p_single_walk_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !rsp_valid && !mem_req);

endmodule

bind sect_xlate sect_xlate_chk #(.VA_W(VA_W), .SECT_W(SECT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .xl_en     (xl_en),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_va    (req_va),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_pa    (rsp_pa),
    .rsp_cache (rsp_cache),
    .rsp_buf   (rsp_buf),
    .rsp_dom   (rsp_dom),
    .rsp_fault (rsp_fault),
    .mem_req   (mem_req),
    .mem_gnt   (mem_gnt),
    .mem_addr  (mem_addr)
);

// File: tb/sect_xlate_test.sv
module sect_xlate_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xl_en = 1'b0;
    logic [31:0] tbl_base = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_va = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [31:0] rsp_pa;
    logic        rsp_cache, rsp_buf, rsp_fault;
    logic [3:0]  rsp_dom;
    logic        mem_req;
    logic        mem_gnt = 1'b0;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    sect_xlate uut (
        .clk(clk), .rst_n(rst_n), .xl_en(xl_en), .tbl_base(tbl_base),
        .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_pa(rsp_pa),
        .rsp_cache(rsp_cache), .rsp_buf(rsp_buf), .rsp_dom(rsp_dom),
        .rsp_fault(rsp_fault), .mem_req(mem_req), .mem_gnt(mem_gnt),
        .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 req_ready", {31'd0, req_ready}, 32'd1);
        chk("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
        chk("R1 mem_req",   {31'd0, mem_req},   32'd0);
    endtask

    task automatic t_bypass(input logic [31:0] va);
        @(negedge clk);
        xl_en = 1'b0; req_valid = 1'b1; req_va = va;
        @(negedge clk);
        req_valid = 1'b0; req_va = '0; xl_en = 1'b1;
        chk("R2 rsp_valid", {31'd0, rsp_valid}, 32'd1);
        chk("R2 mem_req",   {31'd0, mem_req},   32'd0);
        chk("R2 pa",        rsp_pa, va);
        chk("R2 attrs",     {25'd0, rsp_cache, rsp_buf, rsp_dom, rsp_fault}, 32'h40);
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        chk("R9 taken", {30'd0, rsp_valid, req_ready}, 32'd1);
    endtask

    task automatic t_walk(input string tag, input logic [31:0] va, input logic [31:0] base,
                          input logic [31:0] desc, input int gnt_wait, input int rsp_wait);
        logic [31:0] e_addr, e_pa;
        logic        e_c, e_b, e_f;
        logic [3:0]  e_d;
        e_addr = {base[31:14], va[31:20], 2'b00};
        if (desc[1:0] == 2'b10 && !desc[18]) begin
            e_pa = {desc[31:20], va[19:0]};
            e_c = desc[3]; e_b = desc[2]; e_d = desc[8:5]; e_f = 1'b0;
        end else begin
            e_pa = '0; e_c = 1'b0; e_b = 1'b0; e_d = '0; e_f = 1'b1;
        end
        @(negedge clk);
        xl_en = 1'b1; tbl_base = base; req_valid = 1'b1; req_va = va;
        @(negedge clk);
        req_valid = 1'b0; tbl_base = ~base; req_va = '0; xl_en = 1'b0;
        chk({"R4 req ", tag}, {31'd0, mem_req}, 32'd1);
        chk({"R9 busy ", tag}, {31'd0, req_ready}, 32'd0);
        chk({"R3 addr ", tag}, mem_addr, e_addr);
        for (int i = 0; i < gnt_wait; i++) begin
            @(negedge clk);
            chk({"R4 hold ", tag}, {mem_req, mem_addr[30:0]}, {1'b1, e_addr[30:0]});
        end
        mem_gnt = 1'b1;
        @(negedge clk);
        mem_gnt = 1'b0; mem_rvalid = 1'b1; mem_rdata = desc;
        @(negedge clk);
        mem_rvalid = 1'b0; mem_rdata = 32'hFFFF_FFFF;
        chk({"R5 valid ", tag}, {31'd0, rsp_valid}, 32'd1);
        chk({"R5 pa ", tag}, rsp_pa, e_pa);
        chk({"R6 cb ", tag}, {30'd0, rsp_cache, rsp_buf}, {30'd0, e_c, e_b});
        chk({"R7 dom ", tag}, {28'd0, rsp_dom}, {28'd0, e_d});
        chk({"R8 fault ", tag}, {31'd0, rsp_fault}, {31'd0, e_f});
        for (int i = 0; i < rsp_wait; i++) begin
            @(negedge clk);
            chk({"R9 stable ", tag}, rsp_pa, e_pa);
            chk({"R9 held ", tag}, {31'd0, rsp_valid}, 32'd1);
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        chk({"R9 taken ", tag}, {30'd0, rsp_valid, req_ready}, 32'd1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_bypass(32'h1230_ABCD);
        t_walk("identity", 32'h2020_0010, 32'h0000_4000, 32'h2020_0002, 0, 0);
        t_walk("remap",    32'h1230_ABCD, 32'h0000_4000, 32'h4560_006E, 3, 0);
        t_walk("dirtybase",32'h0030_1234, 32'h0080_7FFF, 32'h0010_01E6, 1, 2);
        t_walk("type00",   32'h0010_0000, 32'h0000_4000, 32'h4560_01EC, 0, 0);
        t_walk("type01",   32'h0020_0000, 32'h0000_4000, 32'h4560_01ED, 0, 0);
        t_walk("type11",   32'h0030_0000, 32'h0000_4000, 32'h4560_01EF, 0, 0);
        t_walk("bit18",    32'h0040_0000, 32'h0000_4000, 32'h4564_01EE, 0, 1);
        t_walk("top",      32'hFFFF_FFFF, 32'hFFFF_C000, 32'hABC0_000A, 2, 4);
        t_bypass(32'hFFF0_0001);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule